// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits on the host side of a byte-lane parallel NOR flash. It turns one request into the bus traffic that the flash expects. A request is one of three kinds: program a byte, erase a set of 64 KB sectors, or erase the whole array. The block first sends the unlock and command writes. Each write is framed by a write-strobe pulse of a fixed number of clock cycles. The block then reads the target location over and over until the flash signals that its internal operation is complete.

A flash that is still busy returns the inverse of the most significant data bit. The block compares that bit against the value it expects after completion. When the two match it ends with a one-cycle `done`. If they never match within a bounded number of reads, it ends with a one-cycle `timeout`. The select line of the companion static RAM is held inactive at all times.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is idle. `busy` is 0, `flash_sel_n`, `flash_wr_n`, `flash_rd_n` and `ram_sel_n` are 1, and `bus_drive` is 0.
- R2: Request code 2'b00 (program) produces exactly four writes, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (`cmd_addr`, `cmd_data`).
- R3: Request code 2'b10 (chip erase) produces exactly six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then (5555h, 10h).
- R4: Request code 2'b01 (sector erase) sends the same first five writes as R3. It then writes 30h once to the base of every sector whose bit is set in `cmd_sectors`, lowest sector first. Sector i has base address i << 16, so the sector number sits in address bits 18:16.
- R5: Each write keeps `flash_sel_n` low and `bus_drive` high. It holds `flash_wr_n` low for exactly WP_CYC cycles (3 by default), with one setup cycle before the pulse and WPH_CYC cycles (2) after it. Address and data stay constant while the strobe is low.
- R6: After the last write the block releases the data bus, drives `flash_rd_n` low, and holds the poll address. The poll address is `cmd_addr` for a program, the lowest selected sector base for a sector erase, and 0 for a chip erase. The block samples `flash_din[7]` every cycle after an OE_CYC-cycle settle. It pulses `done` when that bit equals the expected value: `cmd_data[7]` for a program, 1 for any erase.
- R7: If the bit does not match on any of POLL_LIMIT consecutive samples, the block pulses `timeout`, raises no `done`, and returns to idle. Over the whole poll, `flash_rd_n` stays low for OE_CYC + POLL_LIMIT cycles.
- R8: The block ignores requests while `busy` is high. It also ignores the reserved code 2'b11 and a sector erase with an all-zero mask: for these it makes no write and does not raise `busy`.
- R9: `ram_sel_n` stays high in every cycle.
- R10: `done` and `timeout` each last one cycle, never occur together, and occur only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request strobe, taken when idle |
| cmd_op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| cmd_addr | input | ADDR_W | Byte address for a program |
| cmd_data | input | 8 | Byte to program |
| cmd_sectors | input | SECT_N | Sector mask for sector erase |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle poll-timeout pulse |
| flash_addr | output | ADDR_W | Flash address |
| flash_dout | output | 8 | Write data toward the flash |
| bus_drive | output | 1 | Data bus driven by this block |
| flash_din | input | 8 | Read data from the flash |
| flash_sel_n | output | 1 | Flash select, active low |
| flash_wr_n | output | 1 | Flash write strobe, active low |
| flash_rd_n | output | 1 | Flash read enable, active low |
| ram_sel_n | output | 1 | Static RAM select, held inactive |

## Verification
A step counter or sector mask in the wrong state shows up within one write frame. The next strobe pulse then carries the wrong address/data pair or arrives out of order, so a log of every rising write strobe exposes it. A wrong expected-bit polarity or a bad poll counter shows up at the end of the poll. The block then finishes one sample early, finishes late, or times out at the wrong read count, so the count of read cycles is checked exactly against the busy period of the flash model. A wrong strobe timing is caught on the very pulse where it happens.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W     = 19,
  parameter int SECT_N     = 8,
  parameter int WP_CYC     = 3,
  parameter int WPH_CYC    = 2,
  parameter int OE_CYC     = 1,
  parameter int POLL_LIMIT = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [SECT_N-1:0] cmd_sectors,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [7:0]        flash_dout,
  output logic              bus_drive,
  input  logic [7:0]        flash_din,
  output logic              flash_sel_n,
  output logic              flash_wr_n,
  output logic              flash_rd_n,
  output logic              ram_sel_n
);
  localparam int SIDX_W = $clog2(SECT_N);
  localparam int SECT_SH = ADDR_W - SIDX_W;
  localparam int TW = $clog2(WP_CYC + WPH_CYC + OE_CYC + 1) + 1;
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [1:0] OP_PROG = 2'b00, OP_SECT = 2'b01, OP_CHIP = 2'b10;
  localparam logic [ADDR_W-1:0] UA1 = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] UA2 = ADDR_W'(16'h2AAA);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_OEWAIT, S_POLL} st_t;

  st_t st;
  logic [1:0]        op;
  logic [ADDR_W-1:0] tgt, poll_addr, cur_a, sec_base;
  logic [7:0]        wdat, cur_d;
  logic [SECT_N-1:0] pend;
  logic [2:0]        step;
  logic [TW-1:0]     tcnt;
  logic [PW-1:0]     pcnt;
  logic              exp7, done_q, tmo_q, last_wr, accept, writing, reading;

  function automatic logic [SIDX_W-1:0] lowest(input logic [SECT_N-1:0] m);
    lowest = '0;
    for (int i = SECT_N - 1; i >= 0; i--)
      if (m[i]) lowest = i[SIDX_W-1:0];
  endfunction

  wire unused_din = ^flash_din[6:0];

  assign accept   = cmd_valid && cmd_op != 2'b11 && !(cmd_op == OP_SECT && cmd_sectors == '0);
  assign sec_base = {lowest(pend), {SECT_SH{1'b0}}};
  assign last_wr  = (op == OP_PROG && step == 3'd3) || (op == OP_CHIP && step == 3'd5) ||
                    (op == OP_SECT && step == 3'd5 && (pend & (pend - 1'b1)) == '0);

  always_comb begin
    cur_a = UA1;
    cur_d = 8'hAA;
    case (step)
      3'd0: begin cur_a = UA1; cur_d = 8'hAA; end
      3'd1: begin cur_a = UA2; cur_d = 8'h55; end
      3'd2: begin cur_a = UA1; cur_d = (op == OP_PROG) ? 8'hA0 : 8'h80; end
      3'd3: begin
        cur_a = (op == OP_PROG) ? tgt : UA1;
        cur_d = (op == OP_PROG) ? wdat : 8'hAA;
      end
      3'd4: begin cur_a = UA2; cur_d = 8'h55; end
      default: begin
        cur_a = (op == OP_CHIP) ? UA1 : sec_base;
        cur_d = (op == OP_CHIP) ? 8'h10 : 8'h30;
      end
    endcase
  end

  assign writing     = st == S_SETUP || st == S_LOW || st == S_HIGH;
  assign reading     = st == S_OEWAIT || st == S_POLL;
  assign busy        = st != S_IDLE;
  assign done        = done_q;
  assign timeout     = tmo_q;
  assign bus_drive   = writing;
  assign flash_sel_n = st == S_IDLE;
  assign flash_wr_n  = st != S_LOW;
  assign flash_rd_n  = !reading;
  assign flash_addr  = writing ? cur_a : (reading ? poll_addr : '0);
  assign flash_dout  = writing ? cur_d : 8'h00;
  assign ram_sel_n   = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op <= OP_PROG;
      tgt <= '0;
      wdat <= '0;
      pend <= '0;
      step <= '0;
      tcnt <= '0;
      pcnt <= '0;
      poll_addr <= '0;
      exp7 <= 1'b0;
      done_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op   <= cmd_op;
          tgt  <= cmd_addr;
          wdat <= cmd_data;
          pend <= cmd_sectors;
          step <= '0;
          tcnt <= '0;
          exp7 <= (cmd_op == OP_PROG) ? cmd_data[7] : 1'b1;
          poll_addr <= (cmd_op == OP_PROG) ? cmd_addr :
                       (cmd_op == OP_SECT) ? {lowest(cmd_sectors), {SECT_SH{1'b0}}} : '0;
          st <= S_SETUP;
        end
        S_SETUP: begin
          tcnt <= '0;
          st <= S_LOW;
        end
        S_LOW: begin
          if (tcnt == TW'(WP_CYC - 1)) begin
            tcnt <= '0;
            st <= S_HIGH;
          end else tcnt <= tcnt + 1'b1;
        end
        S_HIGH: begin
          if (tcnt == TW'(WPH_CYC - 1)) begin
            tcnt <= '0;
            st <= last_wr ? S_OEWAIT : S_SETUP;
            if (step < 3'd5) step <= step + 1'b1;
            else pend <= pend & (pend - 1'b1);
          end else tcnt <= tcnt + 1'b1;
        end
        S_OEWAIT: begin
          if (tcnt == TW'(OE_CYC - 1)) begin
            pcnt <= '0;
            st <= S_POLL;
          end else tcnt <= tcnt + 1'b1;
        end
        S_POLL: begin
          if (flash_din[7] == exp7) begin
            done_q <= 1'b1;
            st <= S_IDLE;
          end else if (pcnt == PW'(POLL_LIMIT - 1)) begin
            tmo_q <= 1'b1;
            st <= S_IDLE;
          end else pcnt <= pcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module flash_cmd_seq_chk #(
  parameter int ADDR_W = 19,
  parameter int WP_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              timeout,
  input logic              bus_drive,
  input logic              flash_sel_n,
  input logic              flash_wr_n,
  input logic              flash_rd_n,
  input logic [ADDR_W-1:0] flash_addr,
  input logic [7:0]        flash_dout
);
  logic [7:0] lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowcnt <= '0;
    else if (!flash_wr_n) lowcnt <= lowcnt + 1'b1;
    else lowcnt <= '0;
  end

  p_wr_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_wr_n |-> (!flash_sel_n && bus_drive));
  p_wr_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_wr_n) |-> (lowcnt == 8'(WP_CYC)));
  p_bus_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_wr_n && $past(!flash_wr_n)) |-> ($stable(flash_addr) && $stable(flash_dout)));
  p_read_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_rd_n |-> (!bus_drive && flash_wr_n && !flash_sel_n));
  p_done_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!timeout && !busy));
  p_tmo_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !busy);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_tmo_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .WP_CYC(WP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .timeout(timeout),
  .bus_drive(bus_drive), .flash_sel_n(flash_sel_n), .flash_wr_n(flash_wr_n),
  .flash_rd_n(flash_rd_n), .flash_addr(flash_addr), .flash_dout(flash_dout)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam int AW = 19;
  localparam int SN = 8;
  localparam int PLIM = 64;
  localparam int BUSY_N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic [SN-1:0] cmd_sectors = '0;
  logic busy, done, timeout, bus_drive, flash_sel_n, flash_wr_n, flash_rd_n, ram_sel_n;
  logic [AW-1:0] flash_addr;
  logic [7:0] flash_dout, flash_din;

  int checks = 0, errors = 0, cycles = 0;
  logic [AW-1:0] log_a [0:15];
  logic [7:0] log_d [0:15];
  logic [AW-1:0] exp_a [0:15];
  logic [7:0] exp_d [0:15];
  int log_n = 0, exp_n = 0, lowc = 0, wbad = 0, rd_cnt = 0, rd_addr_bad = 0;
  logic [AW-1:0] exp_poll = '0;
  logic exp7 = 1'b0, stuck = 1'b0, ram_bad = 1'b0, got_done, got_tmo;

  always #10 clk = ~clk;

  flash_cmd_seq #(.POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sectors(cmd_sectors),
    .busy(busy), .done(done), .timeout(timeout), .flash_addr(flash_addr),
    .flash_dout(flash_dout), .bus_drive(bus_drive), .flash_din(flash_din),
    .flash_sel_n(flash_sel_n), .flash_wr_n(flash_wr_n), .flash_rd_n(flash_rd_n),
    .ram_sel_n(ram_sel_n)
  );

  assign flash_din = flash_rd_n ? 8'h00 :
                     {((stuck || rd_cnt <= BUSY_N) ? ~exp7 : exp7), 7'h15};

  always @(negedge clk) begin
    cycles++;
    if (!flash_wr_n) lowc++; else lowc = 0;
    if (rst_n && !ram_sel_n) ram_bad = 1'b1;
    if (!flash_rd_n) begin
      rd_cnt++;
      if (flash_addr != exp_poll) rd_addr_bad++;
    end
  end

  always @(posedge flash_wr_n) begin
    if (rst_n && log_n < 16) begin
      log_a[log_n] = flash_addr;
      log_d[log_n] = flash_dout;
      if (lowc != 3 || flash_sel_n || !bus_drive) wbad++;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic add_exp(input logic [AW-1:0] a, input logic [7:0] d);
    exp_a[exp_n] = a;
    exp_d[exp_n] = d;
    exp_n++;
  endtask

  task automatic prefix_erase();
    add_exp(19'h5555, 8'hAA); add_exp(19'h2AAA, 8'h55); add_exp(19'h5555, 8'h80);
    add_exp(19'h5555, 8'hAA); add_exp(19'h2AAA, 8'h55);
  endtask

  task automatic clear_logs();
    log_n = 0; exp_n = 0; wbad = 0; rd_cnt = 0; rd_addr_bad = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [7:0] d, input logic [SN-1:0] s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_sectors = s;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_end();
    got_done = 1'b0; got_tmo = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done || timeout) begin
        got_done = done; got_tmo = timeout;
        chk(!busy, "R10 busy low at end", busy, 0);
        chk(!(done && timeout), "R10 exclusive end", done, 0);
        break;
      end
    end
    @(negedge clk);
    chk(!done && !timeout, "R10 one-cycle end pulse", {done, timeout}, 0);
  endtask

  task automatic cmp_log(input string req);
    chk(log_n == exp_n, req, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_a[i] == exp_a[i], req, log_a[i], exp_a[i]);
      chk(log_d[i] == exp_d[i], req, log_d[i], exp_d[i]);
    end
    chk(wbad == 0, "R5 strobe width/frame", wbad, 0);
  endtask

  task automatic finish_poll(input string req);
    chk(got_done && !got_tmo, req, {got_done, got_tmo}, 2);
    chk(rd_cnt == BUSY_N + 1, "R6 poll read count", rd_cnt, BUSY_N + 1);
    chk(rd_addr_bad == 0, "R6 poll address", rd_addr_bad, 0);
  endtask

  task automatic t_reset();
    chk(!busy && flash_sel_n && flash_wr_n && flash_rd_n && ram_sel_n && !bus_drive,
        "R1 reset state", {busy, flash_sel_n, flash_wr_n, flash_rd_n, ram_sel_n, bus_drive}, 6'b011110);
  endtask

  task automatic t_program(input logic [AW-1:0] a, input logic [7:0] d);
    clear_logs(); stuck = 1'b0; exp7 = d[7]; exp_poll = a;
    add_exp(19'h5555, 8'hAA); add_exp(19'h2AAA, 8'h55); add_exp(19'h5555, 8'hA0); add_exp(a, d);
    issue(2'b00, a, d, '0);
    wait_end();
    cmp_log("R2 program sequence");
    finish_poll("R6 program done");
  endtask

  task automatic t_chip();
    clear_logs(); stuck = 1'b0; exp7 = 1'b1; exp_poll = '0;
    prefix_erase(); add_exp(19'h5555, 8'h10);
    issue(2'b10, 19'h12345, 8'h00, 8'hFF);
    wait_end();
    cmp_log("R3 chip erase sequence");
    finish_poll("R6 chip erase done");
  endtask

  task automatic t_sector(input logic [SN-1:0] m);
    bit first;
    clear_logs(); stuck = 1'b0; exp7 = 1'b1; first = 1'b1;
    prefix_erase();
    for (int i = 0; i < SN; i++)
      if (m[i]) begin
        add_exp({i[2:0], 16'h0000}, 8'h30);
        if (first) exp_poll = {i[2:0], 16'h0000};
        first = 1'b0;
      end
    issue(2'b01, 19'h00777, 8'h00, m);
    wait_end();
    cmp_log("R4 sector erase sequence");
    finish_poll("R6 sector erase done");
  endtask

  task automatic t_timeout();
    clear_logs(); stuck = 1'b1; exp7 = 1'b0; exp_poll = 19'h40010;
    issue(2'b00, 19'h40010, 8'h11, '0);
    wait_end();
    chk(got_tmo && !got_done, "R7 timeout raised", {got_tmo, got_done}, 2);
    chk(rd_cnt == 1 + PLIM, "R7 poll length", rd_cnt, 1 + PLIM);
    stuck = 1'b0;
  endtask

  task automatic t_busy_ignore();
    clear_logs(); stuck = 1'b0; exp7 = 1'b0; exp_poll = 19'h00100;
    add_exp(19'h5555, 8'hAA); add_exp(19'h2AAA, 8'h55); add_exp(19'h5555, 8'hA0);
    add_exp(19'h00100, 8'h7E);
    issue(2'b00, 19'h00100, 8'h7E, '0);
    repeat (6) @(negedge clk);
    issue(2'b10, 19'h0, 8'h0, 8'h0F);
    wait_end();
    cmp_log("R8 request ignored while busy");
    chk(got_done, "R8 first request completes", got_done, 1);
    repeat (5) @(negedge clk);
    chk(!busy, "R8 no queued request", busy, 0);
  endtask

  task automatic t_rejected(input logic [1:0] op, input logic [SN-1:0] m, input string req);
    bit saw_busy;
    clear_logs(); saw_busy = 1'b0;
    issue(op, 19'h00200, 8'h55, m);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (busy) saw_busy = 1'b1;
    end
    chk(!saw_busy && log_n == 0, req, {saw_busy, log_n[7:0]}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program(19'h1A2B3, 8'h3C);
    t_program(19'h7FFFF, 8'hC5);
    t_chip();
    t_sector(8'b1010_0100);
    t_sector(8'h80);
    t_sector(8'hFF);
    t_timeout();
    t_busy_ignore();
    t_rejected(2'b11, 8'hFF, "R8 reserved code ignored");
    t_rejected(2'b01, 8'h00, "R8 empty sector mask ignored");
    chk(!ram_bad, "R9 RAM select held high", ram_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule